// File: doc/BRIEF.md
# Half-Word Masked PHY Control Register Bank

This block is a small bank of 32-bit control registers for a PHY. On every write, the upper half of the write word is a per-bit enable for the lower half. Software can therefore set or clear any group of bits in one bus write, with no read-modify-write and no risk of disturbing bits it did not mean to touch. Bit x of a register changes only if bit x+16 of the same write word is 1.

The bank holds three registers. The configuration word drives a 4-bit data field, a 6-bit address field and a strobe bit into the PHY's internal configuration port. The lane power-off word holds one idle bit per lane. The read-only status word reports the PLL lock state and whether PLL output enable is still pending. A plain bus port with an address, write data, a write strobe and registered read data reaches all three registers. Each register sits at a fixed byte offset.

Top module: `hwm_phy_regbank`

## Requirements
- R1: On a write to a writable register, each storable lower bit x takes bit x of the write word when bit x+16 is 1. It keeps its previous value when bit x+16 is 0.
- R2: The configuration register stores bits [10:0]. Bits [10:7] drive `cfg_data_o`, bits [6:1] drive `cfg_addr_o` and bit 0 drives `cfg_strobe_o`. The outputs follow the register in the cycle after the write edge.
- R3: The lane power-off register stores bits [6:3]. Bit 3+n drives `lane_idle_o[n]` for lanes 0 to 3.
- R4: The status register reads `pll_locked_i` at bit 9 and `pll_out_pend_i` at bit 10, sampled through one register stage. All other status bits read 0.
- R5: The byte offsets are fixed: 0xE220 selects configuration, 0xE214 selects lane power-off and 0xE2A4 selects status. The bank matches the full address exactly.
- R6: `rdata_o` is registered. It shows the selected register's lower 16 stored bits one clock after the address is presented, and bits [31:16] read as 0.
- R7: A write to the status offset changes no register. A write to any other unmapped address has no effect, and reading an unmapped address returns 0.
- R8: Synchronous reset clears every stored bit, every PHY-side output and `rdata_o` to 0.
- R9: Bits outside the defined fields cannot be stored. Configuration bits [15:11] and lane bits [15:7] and [2:0] always read 0, whatever the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | 16 | Byte address of the access |
| bus_wdata_i | input | 32 | Write word: [31:16] per-bit enable, [15:0] data |
| bus_we_i | input | 1 | Write strobe, one write per cycle it is high |
| rdata_o | output | 32 | Registered read data |
| pll_locked_i | input | 1 | PLL lock indication from the PHY |
| pll_out_pend_i | input | 1 | PLL output-enable pending from the PHY |
| cfg_data_o | output | 4 | Configuration data field to the PHY |
| cfg_addr_o | output | 6 | Configuration address field to the PHY |
| cfg_strobe_o | output | 1 | Configuration write strobe to the PHY |
| lane_idle_o | output | 4 | Per-lane idle/off control |

## Verification
The assertions assume three things about the inputs. The address and write strobe are stable and known at every clock edge after reset. A write lasts exactly the cycles in which `bus_we_i` is high. The PLL status inputs change only between edges. The bench drives every input on the falling edge and reads the outputs on the falling edge. It keeps the address fixed for a whole cycle before it samples `rdata_o`, and it moves the status inputs only while no status read is in flight. Expected register contents come from a mask-and-merge model in the bench, which runs over pseudo-random data and mask words, over single-bit masks, and over mapped, unmapped and misaligned addresses.

// File: rtl/hwm_pkg.sv
package hwm_pkg;
  localparam int unsigned HALF_W       = 16;
  localparam int unsigned WORD_W       = 2 * HALF_W;
  localparam int unsigned CFG_DATA_LSB = 7;
  localparam int unsigned CFG_DATA_W   = 4;
  localparam int unsigned CFG_ADDR_LSB = 1;
  localparam int unsigned CFG_ADDR_W   = 6;
  localparam int unsigned CFG_STB_BIT  = 0;
  localparam int unsigned LANE_LSB     = 3;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_LANE = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  function automatic logic [HALF_W-1:0] field_mask(input int unsigned lsb, input int unsigned width);
    logic [HALF_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(HALF_W); i++) begin
      if (i >= int'(lsb) && i < int'(lsb + width)) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/hwm_reg.sv
module hwm_reg #(
  parameter int unsigned HALF_W = 16,
  parameter logic [HALF_W-1:0] KEEP_MASK = '1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en_i,
  input  logic [2*HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0]   q_o
);
  logic [HALF_W-1:0] q;
  logic [HALF_W-1:0] bit_en;
  logic [HALF_W-1:0] bit_val;

  assign bit_en  = wdata_i[2*HALF_W-1:HALF_W];
  assign bit_val = wdata_i[HALF_W-1:0];

  for (genvar i = 0; i < int'(HALF_W); i++) begin : g_bit
    if (KEEP_MASK[i]) begin : g_store
      always_ff @(posedge clk) begin
        if (rst)                       q[i] <= 1'b0;
        else if (wr_en_i && bit_en[i]) q[i] <= bit_val[i];
      end
    end else begin : g_tied
      assign q[i] = 1'b0;
    end
  end

  assign q_o = q;

  AST_UNMASKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (((q ^ $past(q)) & ~$past(bit_en)) == '0)); // R1
  AST_MASKED_TAKE: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (((q ^ $past(bit_val)) & $past(bit_en) & KEEP_MASK) == '0)); // R1
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(q)); // R7
endmodule

// File: rtl/hwm_stat_sample.sv
module hwm_stat_sample #(
  parameter int unsigned HALF_W   = 16,
  parameter int unsigned LOCK_BIT = 9,
  parameter int unsigned PEND_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pll_locked_i,
  input  logic              pll_out_pend_i,
  output logic [HALF_W-1:0] stat_o
);
  logic lock_q;
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      lock_q <= pll_locked_i;
      pend_q <= pll_out_pend_i;
    end
  end

  always_comb begin
    stat_o           = '0;
    stat_o[LOCK_BIT] = lock_q;
    stat_o[PEND_BIT] = pend_q;
  end

  AST_LOCK_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stat_o[LOCK_BIT] == $past(pll_locked_i))); // R4
endmodule

// File: rtl/hwm_phy_regbank.sv
module hwm_phy_regbank
  import hwm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] CFG_OFFSET  = 16'hE220,
  parameter logic [ADDR_W-1:0] LANE_OFFSET = 16'hE214,
  parameter logic [ADDR_W-1:0] STAT_OFFSET = 16'hE2A4,
  parameter int unsigned NUM_LANES   = 4,
  parameter int unsigned LOCK_BIT    = 9,
  parameter int unsigned PEND_BIT    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  input  logic              bus_we_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic              pll_locked_i,
  input  logic              pll_out_pend_i,
  output logic [CFG_DATA_W-1:0] cfg_data_o,
  output logic [CFG_ADDR_W-1:0] cfg_addr_o,
  output logic              cfg_strobe_o,
  output logic [NUM_LANES-1:0]  lane_idle_o
);
  localparam logic [HALF_W-1:0] CFG_KEEP =
    field_mask(CFG_DATA_LSB, CFG_DATA_W) | field_mask(CFG_ADDR_LSB, CFG_ADDR_W) |
    field_mask(CFG_STB_BIT, 1);
  localparam logic [HALF_W-1:0] LANE_KEEP = field_mask(LANE_LSB, NUM_LANES);

  reg_sel_e          sel;
  logic [HALF_W-1:0] cfg_q;
  logic [HALF_W-1:0] lane_q;
  logic [HALF_W-1:0] stat_q;
  logic [HALF_W-1:0] rd_mux;

  always_comb begin
    if (bus_addr_i == CFG_OFFSET)       sel = SEL_CFG;
    else if (bus_addr_i == LANE_OFFSET) sel = SEL_LANE;
    else if (bus_addr_i == STAT_OFFSET) sel = SEL_STAT;
    else                                sel = SEL_NONE;
  end

  hwm_reg #(.HALF_W(HALF_W), .KEEP_MASK(CFG_KEEP)) u_cfg (
    .clk(clk), .rst(rst),
    .wr_en_i(bus_we_i && (sel == SEL_CFG)),
    .wdata_i(bus_wdata_i), .q_o(cfg_q)
  );

  hwm_reg #(.HALF_W(HALF_W), .KEEP_MASK(LANE_KEEP)) u_lane (
    .clk(clk), .rst(rst),
    .wr_en_i(bus_we_i && (sel == SEL_LANE)),
    .wdata_i(bus_wdata_i), .q_o(lane_q)
  );

  hwm_stat_sample #(.HALF_W(HALF_W), .LOCK_BIT(LOCK_BIT), .PEND_BIT(PEND_BIT)) u_stat (
    .clk(clk), .rst(rst),
    .pll_locked_i(pll_locked_i), .pll_out_pend_i(pll_out_pend_i),
    .stat_o(stat_q)
  );

  always_comb begin
    unique case (sel)
      SEL_CFG:  rd_mux = cfg_q;
      SEL_LANE: rd_mux = lane_q;
      SEL_STAT: rd_mux = stat_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= {{(WORD_W-HALF_W){1'b0}}, rd_mux};
  end

  assign cfg_data_o   = cfg_q[CFG_DATA_LSB +: CFG_DATA_W];
  assign cfg_addr_o   = cfg_q[CFG_ADDR_LSB +: CFG_ADDR_W];
  assign cfg_strobe_o = cfg_q[CFG_STB_BIT];
  assign lane_idle_o  = lane_q[LANE_LSB +: NUM_LANES];

  AST_STAT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (bus_we_i && sel == SEL_STAT) |=> ($stable(cfg_q) && $stable(lane_q))); // R7
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_NONE) |=> (rdata_o == '0)); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (cfg_q == '0 && lane_q == '0 && rdata_o == '0)); // R8
  AST_CFG_READBACK: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_CFG && !bus_we_i) |=> (rdata_o[HALF_W-1:0] == cfg_q)); // R6
endmodule

// File: tb/tb_hwm_phy_regbank.sv
module tb_hwm_phy_regbank;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_CFG  = 16'hE220;
  localparam logic [15:0] A_LANE = 16'hE214;
  localparam logic [15:0] A_STAT = 16'hE2A4;
  localparam logic [15:0] CFG_KEEP  = 16'h07FF;
  localparam logic [15:0] LANE_KEEP = 16'h0078;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = 16'h0;
  logic [31:0] wdata = 32'h0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        lock_in = 1'b0;
  logic        pend_in = 1'b0;
  logic [3:0]  cfg_data;
  logic [5:0]  cfg_addr;
  logic        cfg_stb;
  logic [3:0]  lane_idle;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_cfg = 16'h0;
  logic [15:0] exp_lane = 16'h0;
  logic [31:0] seed = 32'h1D2C3B4A;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwm_phy_regbank dut (
    .clk(clk), .rst(rst), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_we_i(we),
    .rdata_o(rdata), .pll_locked_i(lock_in), .pll_out_pend_i(pend_in),
    .cfg_data_o(cfg_data), .cfg_addr_o(cfg_addr), .cfg_strobe_o(cfg_stb),
    .lane_idle_o(lane_idle)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [31:0] w,
                                        input logic [15:0] keep);
    return ((old & ~w[31:16]) | (w[15:0] & w[31:16])) & keep;
  endfunction

  task automatic bus_wr(input logic [15:0] a, input logic [31:0] w);
    @(negedge clk);
    addr = a; wdata = w; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    if (a == A_CFG)  exp_cfg  = merge(exp_cfg, w, CFG_KEEP);
    if (a == A_LANE) exp_lane = merge(exp_lane, w, LANE_KEEP);
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [31:0] r);
    @(negedge clk);
    addr = a; we = 1'b0;
    @(negedge clk);
    r = rdata;
  endtask

  task automatic chk_all(input string tag);
    logic [31:0] r;
    bus_rd(A_CFG, r);  chk({tag, " R6 cfg read"}, r, {16'h0, exp_cfg});
    bus_rd(A_LANE, r); chk({tag, " R6 lane read"}, r, {16'h0, exp_lane});
    chk({tag, " R2 fields"}, {21'h0, cfg_data, cfg_addr, cfg_stb}, {21'h0, exp_cfg[10:0]});
    chk({tag, " R3 lanes"}, {28'h0, lane_idle}, {28'h0, exp_lane[6:3]});
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 rdata", rdata, 32'h0);
    chk("R8 outputs", {17'h0, lane_idle, cfg_data, cfg_addr, cfg_stb}, 32'h0);
    rst = 1'b0;
    chk_all("R8 post-reset");

    // R1 R9: single-bit masks, data all ones then all zeros
    for (int b = 0; b < 16; b++) begin
      bus_wr(A_CFG, {16'h1 << b, 16'hFFFF});
      bus_wr(A_LANE, {16'h1 << b, 16'hFFFF});
      chk_all("R1 R9 setbit");
    end
    for (int b = 0; b < 16; b++) begin
      bus_wr(A_CFG, {16'h1 << b, 16'h0000});
      bus_wr(A_LANE, {16'h1 << b, 16'h0000});
      chk_all("R1 clrbit");
    end
    // R1: empty mask changes nothing
    bus_wr(A_CFG, 32'h0000_FFFF);
    chk_all("R1 nomask");

    // R1 R2 R3 R5: pseudo-random data/mask sweep
    for (int k = 0; k < 300; k++) begin
      seed = nxt(seed);
      bus_wr(A_CFG, seed);
      seed = nxt(seed);
      bus_wr(A_LANE, seed);
      chk_all("R1 R5 sweep");
    end

    // R7: status and unmapped writes ignored
    bus_wr(A_CFG, 32'hFFFF_0155);
    bus_wr(A_LANE, 32'hFFFF_0028);
    bus_wr(A_STAT, 32'hFFFF_FFFF);
    chk_all("R7 stat write");
    bus_rd(A_STAT, r); chk("R7 stat unchanged", r, 32'h0);
    foreach (r[i]) begin end
    begin
      logic [15:0] bad [6] = '{16'hE218, 16'hE221, 16'hE224, 16'h0000, 16'hE2A0, 16'hF220};
      foreach (bad[i]) begin
        bus_wr(bad[i], 32'hFFFF_FFFF);
        bus_rd(bad[i], r);
        chk("R7 unmapped read", r, 32'h0);
        chk_all("R7 unmapped write");
      end
    end

    // R4: status bit mapping over all input combinations
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      lock_in = c[0]; pend_in = c[1];
      @(negedge clk);
      bus_rd(A_STAT, r);
      chk("R4 status", r, {21'h0, c[1], c[0], 9'h0});
    end
    lock_in = 1'b0; pend_in = 1'b0;

    // R8: mid-run reset
    bus_wr(A_CFG, 32'hFFFF_FFFF);
    bus_wr(A_LANE, 32'hFFFF_FFFF);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R8 mid rdata", rdata, 32'h0);
    chk("R8 mid outputs", {17'h0, lane_idle, cfg_data, cfg_addr, cfg_stb}, 32'h0);
    rst = 1'b0;
    exp_cfg = 16'h0; exp_lane = 16'h0;
    chk_all("R8 mid cleared");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule